// File: doc/BRIEF.md
# Transparent Registered Read Port

This block is a memory read port whose result leaves through an output register. It carries its own word array, written by several write ports that all run on the read port's clock. Each write port can cover one word or a power-of-two group of words, with a separate enable for every data bit. The read port can also span a power-of-two group of words. Group sizes are parameters, and read and write groups need not match in size.

When built as transparent, the port returns the newest data. The word group fetched from the array is patched with the data being written in the same cycle, and only then captured. Patching is done per write port, in port order, and per bit. Only bits whose write enable is set are patched, and only where the written word address equals the read word address. Words are compared one at a time, so a wide write can reach a narrow read and a wide read can pick up a narrow write in any of its words. When built as non-transparent, the port returns the data held before that edge's writes.

The output register has a read enable and an initial value. It has one reset input, which a parameter treats as either synchronous or asynchronous, each with its own reset value. A second parameter decides whether a synchronous reset needs the read enable.

Top module: `xp_rdport`

## Requirements
- R1: With TRANSPARENT=0, `rd_data` after a rising edge with `rd_en` high equals the array words at the read address as held before that edge, even when that edge also writes them.
- R2: With TRANSPARENT=1, a bit of a read word that a write port enables at the same word address in the same cycle shows the write data after the edge. Bits with their enable clear show the array value.
- R3: When several write ports enable the same bit of the same word in one cycle, the highest-numbered port's data wins, both in the transparent result and in the array.
- R4: A write port spanning 2^k words writes the aligned group that contains its address; the low k address bits are ignored. Each of its words reaches a narrower read that covers that word.
- R5: A read spanning 2^j words returns the aligned group containing `rd_addr`, lowest word in the least significant byte; the low j address bits are ignored. A narrower write to any one word of the group is bypassed into that word only.
- R6: With `rd_en` low and no reset, `rd_data` holds its value across the edge, whatever is written.
- R7: With RST_KIND synchronous and CE_OVER_SRST=1, `rst` loads SRST_VAL at a rising edge only when `rd_en` is high. With `rst` high and `rd_en` low the output holds, and nothing changes between edges.
- R8: With RST_KIND asynchronous, raising `rst` sets `rd_data` to ARST_VAL at once, without waiting for a clock edge.
- R9: Before any reset or capture, `rd_data` shows INIT_VAL.
- R10: A write to a word outside the read group leaves the registered result equal to the old array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the read port and every write port |
| rst | input | 1 | Output register reset, synchronous or asynchronous according to RST_KIND |
| rd_en | input | 1 | Read enable; the output register loads only when it is high |
| rd_addr | input | AW | Word address of the read; low RD_WL bits ignored |
| rd_data | output | DW<<RD_WL | Registered read result |
| wr_addr | input | NWR*AW | Word address per write port, port 0 in the low field |
| wr_data | input | sum of DW<<wl per port | Write data, packed from port 0 upward |
| wr_bmask | input | same as wr_data | Per-bit write enable, same layout as wr_data |

## Verification
Every read result appears one rising edge after the cycle whose inputs produced it. Reads, bypass, hold and the synchronous reset all behave this way. The one exception is the asynchronous reset, which shows within the same cycle. Array writes take effect at that same edge, so only the following read row observes them. The bench changes inputs on falling edges and samples one nanosecond after each rising edge. It checks the asynchronous reset between edges, and checks the initial value before the first edge.

// File: rtl/xp_pkg.sv
package xp_pkg;

  typedef enum logic {RK_SYNC, RK_ASYNC} rst_kind_e;

  // word-group size (log2) of write port p, two bits per port
  function automatic int unsigned port_wl(logic [31:0] pack, int unsigned p);
    return 32'((pack >> (2 * p)) & 32'h3);
  endfunction

  function automatic int unsigned port_bits(logic [31:0] pack, int unsigned p, int unsigned dw);
    return dw << port_wl(pack, p);
  endfunction

  // bit offset of port p inside the packed write buses
  function automatic int unsigned port_off(logic [31:0] pack, int unsigned p, int unsigned dw);
    int unsigned s;
    s = 0;
    for (int unsigned q = 0; q < p; q++) s += port_bits(pack, q, dw);
    return s;
  endfunction

  function automatic int unsigned max_wl(logic [31:0] pack, int unsigned n);
    int unsigned m;
    m = 0;
    for (int unsigned q = 0; q < n; q++)
      if (port_wl(pack, q) > m) m = port_wl(pack, q);
    return m;
  endfunction

  // word address of slot idx inside the aligned group of 2^wl words
  function automatic int unsigned word_at(int unsigned addr, int unsigned wl, int unsigned idx);
    return ((addr >> wl) << wl) | idx;
  endfunction

endpackage

// File: rtl/xp_lanes.sv
// Spreads every write port into uniform single-word lanes.
module xp_lanes #(
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 4,
  parameter int unsigned NWR   = 2,
  parameter logic [31:0] WR_WL = 32'h8,
  localparam int unsigned WR_BITS = xp_pkg::port_off(WR_WL, NWR, DW),
  localparam int unsigned WMAX    = 1 << xp_pkg::max_wl(WR_WL, NWR),
  localparam int unsigned NLANE   = NWR * WMAX
) (
  input  logic [NWR*AW-1:0]   wr_addr,
  input  logic [WR_BITS-1:0]  wr_data,
  input  logic [WR_BITS-1:0]  wr_bmask,
  output logic [NLANE*AW-1:0] ln_addr,
  output logic [NLANE*DW-1:0] ln_data,
  output logic [NLANE*DW-1:0] ln_mask
);
  for (genvar p = 0; p < NWR; p++) begin : g_port
    localparam int unsigned PWL  = xp_pkg::port_wl(WR_WL, p);
    localparam int unsigned POFF = xp_pkg::port_off(WR_WL, p, DW);
    for (genvar w = 0; w < WMAX; w++) begin : g_word
      localparam int unsigned L = p * WMAX + w;
      if (w < (1 << PWL)) begin : g_on
        assign ln_addr[L*AW +: AW] = AW'(xp_pkg::word_at(32'(wr_addr[p*AW +: AW]), PWL, w));
        assign ln_data[L*DW +: DW] = wr_data[POFF + w*DW +: DW];
        assign ln_mask[L*DW +: DW] = wr_bmask[POFF + w*DW +: DW];
      end else begin : g_off
        assign ln_addr[L*AW +: AW] = '0;
        assign ln_data[L*DW +: DW] = '0;
        assign ln_mask[L*DW +: DW] = '0;
      end
    end
  end
endmodule

// File: rtl/xp_store.sv
// Word array: lane writes in lane order, combinational group read.
module xp_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 4,
  parameter int unsigned NLANE = 8,
  parameter int unsigned RD_WL = 1,
  localparam int unsigned DEPTH  = 1 << AW,
  localparam int unsigned RWORDS = 1 << RD_WL
) (
  input  logic                   clk,
  input  logic [NLANE*AW-1:0]    ln_addr,
  input  logic [NLANE*DW-1:0]    ln_data,
  input  logic [NLANE*DW-1:0]    ln_mask,
  input  logic [AW-1:0]          rd_addr,
  output logic [RWORDS*DW-1:0]   raw_q
);
  logic [DW-1:0] cell_q [DEPTH];

  // later lanes (higher port numbers) are assigned last and win
  always_ff @(posedge clk) begin
    for (int l = 0; l < NLANE; l++)
      for (int b = 0; b < DW; b++)
        if (ln_mask[l*DW + b])
          cell_q[ln_addr[l*AW +: AW]][b] <= ln_data[l*DW + b];
  end

  for (genvar r = 0; r < RWORDS; r++) begin : g_rd
    assign raw_q[r*DW +: DW] = cell_q[AW'(xp_pkg::word_at(32'(rd_addr), RD_WL, r))];
  end
endmodule

// File: rtl/xp_merge.sv
// Bypass network: patches the fetched group with same-cycle write bits.
module xp_merge #(
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 4,
  parameter int unsigned NWR   = 2,
  parameter int unsigned WMAX  = 4,
  parameter int unsigned RD_WL = 1,
  localparam int unsigned NLANE  = NWR * WMAX,
  localparam int unsigned RWORDS = 1 << RD_WL
) (
  input  logic [AW-1:0]          rd_addr,
  input  logic [RWORDS*DW-1:0]   raw_q,
  input  logic [NLANE*AW-1:0]    ln_addr,
  input  logic [NLANE*DW-1:0]    ln_data,
  input  logic [NLANE*DW-1:0]    ln_mask,
  output logic [RWORDS*DW-1:0]   merged,
  output logic [NWR*RWORDS-1:0]  lane_hit
);
  always_comb begin
    merged   = raw_q;
    lane_hit = '0;
    // port order is override order: a later port patches over an earlier one
    for (int p = 0; p < NWR; p++)
      for (int w = 0; w < WMAX; w++)
        for (int r = 0; r < RWORDS; r++)
          if (ln_addr[(p*WMAX + w)*AW +: AW] == AW'(xp_pkg::word_at(32'(rd_addr), RD_WL, r))
              && |ln_mask[(p*WMAX + w)*DW +: DW]) begin
            lane_hit[p*RWORDS + r] = 1'b1;
            merged[r*DW +: DW] = (merged[r*DW +: DW] & ~ln_mask[(p*WMAX + w)*DW +: DW])
                               | (ln_data[(p*WMAX + w)*DW +: DW] & ln_mask[(p*WMAX + w)*DW +: DW]);
          end
  end
endmodule

// File: rtl/xp_oreg.sv
// Output register with enable, one reset (sync or async) and initial value.
module xp_oreg #(
  parameter int unsigned        W            = 16,
  parameter xp_pkg::rst_kind_e  RST_KIND     = xp_pkg::RK_SYNC,
  parameter bit                 CE_OVER_SRST = 1'b1,
  parameter logic [W-1:0]       INIT_VAL     = '0,
  parameter logic [W-1:0]       SRST_VAL     = '0,
  parameter logic [W-1:0]       ARST_VAL     = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r = INIT_VAL;

  if (RST_KIND == xp_pkg::RK_ASYNC) begin : g_async
    always_ff @(posedge clk or posedge rst) begin
      if (rst)     q_r <= ARST_VAL;
      else if (en) q_r <= d;
    end
  end else if (CE_OVER_SRST) begin : g_sync_gated
    always_ff @(posedge clk) begin
      if (en) q_r <= rst ? SRST_VAL : d;
    end
  end else begin : g_sync_free
    always_ff @(posedge clk) begin
      if (rst)     q_r <= SRST_VAL;
      else if (en) q_r <= d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/xp_rdport.sv
module xp_rdport #(
  parameter int unsigned        DW           = 8,
  parameter int unsigned        AW           = 4,
  parameter int unsigned        NWR          = 2,
  parameter int unsigned        RD_WL        = 1,
  parameter logic [31:0]        WR_WL        = 32'h8,
  parameter bit                 TRANSPARENT  = 1'b1,
  parameter xp_pkg::rst_kind_e  RST_KIND     = xp_pkg::RK_SYNC,
  parameter bit                 CE_OVER_SRST = 1'b1,
  parameter logic [(DW<<RD_WL)-1:0] INIT_VAL = '0,
  parameter logic [(DW<<RD_WL)-1:0] SRST_VAL = '0,
  parameter logic [(DW<<RD_WL)-1:0] ARST_VAL = '0,
  localparam int unsigned RBITS   = DW << RD_WL,
  localparam int unsigned WR_BITS = xp_pkg::port_off(WR_WL, NWR, DW),
  localparam int unsigned WMAX    = 1 << xp_pkg::max_wl(WR_WL, NWR),
  localparam int unsigned NLANE   = NWR * WMAX
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic [RBITS-1:0]     rd_data,
  input  logic [NWR*AW-1:0]    wr_addr,
  input  logic [WR_BITS-1:0]   wr_data,
  input  logic [WR_BITS-1:0]   wr_bmask
);
  logic [NLANE*AW-1:0] ln_addr;
  logic [NLANE*DW-1:0] ln_data;
  logic [NLANE*DW-1:0] ln_mask;
  logic [RBITS-1:0]    raw_q;
  logic [RBITS-1:0]    reg_d;

  xp_lanes #(.DW(DW), .AW(AW), .NWR(NWR), .WR_WL(WR_WL)) u_lanes (
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_bmask(wr_bmask),
    .ln_addr(ln_addr), .ln_data(ln_data), .ln_mask(ln_mask)
  );

  xp_store #(.DW(DW), .AW(AW), .NLANE(NLANE), .RD_WL(RD_WL)) u_store (
    .clk(clk), .ln_addr(ln_addr), .ln_data(ln_data), .ln_mask(ln_mask),
    .rd_addr(rd_addr), .raw_q(raw_q)
  );

  if (TRANSPARENT) begin : g_bypass
    logic [NWR*(1<<RD_WL)-1:0] lane_hit;
    logic                      any_hit;

    xp_merge #(.DW(DW), .AW(AW), .NWR(NWR), .WMAX(WMAX), .RD_WL(RD_WL)) u_merge (
      .rd_addr(rd_addr), .raw_q(raw_q), .ln_addr(ln_addr), .ln_data(ln_data),
      .ln_mask(ln_mask), .merged(reg_d), .lane_hit(lane_hit)
    );
    assign any_hit = |lane_hit;

    AST_NEW_DATA: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> rd_data == $past(reg_d)); // R2
    AST_QUIET_PASS: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !any_hit) |-> reg_d == raw_q); // R10
  end else begin : g_plain
    assign reg_d = raw_q;

    AST_OLD_DATA: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> rd_data == $past(raw_q)); // R1
  end

  xp_oreg #(
    .W(RBITS), .RST_KIND(RST_KIND), .CE_OVER_SRST(CE_OVER_SRST),
    .INIT_VAL(INIT_VAL), .SRST_VAL(SRST_VAL), .ARST_VAL(ARST_VAL)
  ) u_oreg (
    .clk(clk), .rst(rst), .en(rd_en), .d(reg_d), .q(rd_data)
  );

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R6
endmodule

// File: tb/sim_xp_rdport.sv
`timescale 1ns/1ps
module sim_xp_rdport;
  typedef struct packed {
    logic [3:0]  raddr;
    logic        en;
    logic [3:0]  a0;
    logic [7:0]  d0;
    logic [7:0]  m0;
    logic [3:0]  a1;
    logic [31:0] d1;
    logic [31:0] m1;
    logic [15:0] e0;
    logic [15:0] e1;
  } row_t;

  // array starts as word k = A0+k; u0 transparent, u1 not
  localparam int NROW = 9;
  localparam row_t TBL [NROW] = '{
    '{4'd2, 1'b1, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0,             16'hA3A2, 16'hA3A2},
    '{4'd4, 1'b1, 4'd5, 8'h55, 8'hFF, 4'd0, 32'h0, 32'h0,             16'h55A4, 16'hA5A4},
    '{4'd4, 1'b1, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0,             16'h55A4, 16'h55A4},
    '{4'd6, 1'b1, 4'd0, 8'h00, 8'h00, 4'd6, 32'h3C66_5544, 32'h0F00_FF00, 16'hACA6, 16'hA7A6},
    '{4'd6, 1'b1, 4'd7, 8'hF0, 8'hFF, 4'd4, 32'h1100_0000, 32'h0F00_0000, 16'hF1A6, 16'hACA6},
    '{4'd7, 1'b1, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0,             16'hF1A6, 16'hF1A6},
    '{4'd8, 1'b1, 4'd3, 8'h99, 8'hFF, 4'd0, 32'h0, 32'h0,             16'hA9A8, 16'hA9A8},
    '{4'd2, 1'b0, 4'd2, 8'h00, 8'hFF, 4'd0, 32'h0, 32'h0,             16'hA9A8, 16'hA9A8},
    '{4'd2, 1'b1, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0,             16'h9900, 16'h9900}
  };
  localparam string ROW_REQ [NROW] = '{"R10", "R5", "R1", "R4", "R3", "R5", "R10", "R6", "R6"};

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  wa = '0;
  logic [39:0] wd = '0;
  logic [39:0] wm = '0;
  logic [15:0] q0, q1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xp_rdport #(.TRANSPARENT(1'b1), .RST_KIND(xp_pkg::RK_SYNC), .CE_OVER_SRST(1'b1),
    .INIT_VAL(16'h1111), .SRST_VAL(16'h5A5A), .ARST_VAL(16'h0000)) u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q0),
    .wr_addr(wa), .wr_data(wd), .wr_bmask(wm));

  xp_rdport #(.TRANSPARENT(1'b0), .RST_KIND(xp_pkg::RK_ASYNC), .CE_OVER_SRST(1'b1),
    .INIT_VAL(16'h2222), .SRST_VAL(16'h0000), .ARST_VAL(16'hC3C3)) u1 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q1),
    .wr_addr(wa), .wr_data(wd), .wr_bmask(wm));

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_writes();
    wa = '0; wd = '0; wm = '0;
  endtask

  initial begin
    #1;
    chk(q0, 16'h1111, "R9 u0 initial");
    chk(q1, 16'h2222, "R9 u1 initial");

    @(negedge clk);
    rst = 1'b1; rd_en = 1'b0;
    #1;
    chk(q1, 16'hC3C3, "R8 async reset immediate");
    chk(q0, 16'h1111, "R7 sync reset waits for edge");
    rd_en = 1'b1;
    @(posedge clk); #1;
    chk(q0, 16'h5A5A, "R7 sync reset with enable");

    // fill the array through the wide port, address low bits set on purpose (R4)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wa = {4'(4*k + 1), 4'd0};
      for (int w = 0; w < 4; w++) wd[8 + w*8 +: 8] = 8'(8'hA0 + 4*k + w);
      wd[7:0] = '0;
      wm = {32'hFFFF_FFFF, 8'h00};
    end
    @(negedge clk);
    idle_writes(); rst = 1'b0; rd_en = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      rd_addr = TBL[i].raddr;
      rd_en   = TBL[i].en;
      wa = {TBL[i].a1, TBL[i].a0};
      wd = {TBL[i].d1, TBL[i].d0};
      wm = {TBL[i].m1, TBL[i].m0};
      @(posedge clk); #1;
      chk(q0, TBL[i].e0, {ROW_REQ[i], " transparent"});
      chk(q1, TBL[i].e1, {ROW_REQ[i], " non-transparent"});
    end

    @(negedge clk);
    idle_writes(); rst = 1'b1; rd_en = 1'b0;
    #1;
    chk(q1, 16'hC3C3, "R8 async reset mid-cycle");
    @(posedge clk); #1;
    chk(q0, 16'h9900, "R7 reset ignored while disabled");
    @(negedge clk);
    rd_en = 1'b1;
    @(posedge clk); #1;
    chk(q0, 16'h5A5A, "R7 reset taken when enabled");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule